// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block drives an external dual-slope integrating converter through its four conversion phases by means of a two-bit phase code. A divider derives a system tick from the fast clock. A prescaled timebase, scaled by an 8-bit programmed value, sets how long auto-zero and integrate last. During de-integration a counter runs until the comparator output falls or the counter reaches its full-scale limit. The block then holds the converter's integrator at zero for a fixed time and returns to auto-zero. At that point it publishes the count, a polarity bit and an overrange bit, and pulses a capture strobe.

The host drives the active-low conversion enable low to run conversions back to back. Driving it high parks the converter in auto-zero for as long as it stays high, and any conversion in flight is discarded. The active-low data-valid output is low exactly while the phase code shows auto-zero. Its falling edge after a completed conversion therefore marks fresh data.

Top module: `dslope_sequencer`

## Requirements
- R1: The phase code (bit 1 then bit 0) is 01 for auto-zero, 10 for integrate, 11 for de-integrate and 00 for integrator-zero. Without a forced auto-zero the phases follow the order 01, 10, 11, 00, 01.
- R2: Auto-zero and integrate each last (L+1)*PRE_DIV system ticks. L is the load value, latched on each entry to auto-zero.
- R3: De-integrate ends at the first system tick that sees the comparator low after it was high at the previous tick. The result equals the number of de-integrate ticks before that ending tick.
- R4: The full-scale limit is 2^CNT_W-1 when the range select is 1 and 2^(CNT_W-1)-1 when it is 0. If the count reaches the limit before a comparator fall, de-integrate ends, overrange is 1 and the result equals the limit. A fall on that same tick counts as a normal end with overrange 0.
- R5: The polarity bit is the comparator level sampled at the tick that ends integrate.
- R6: Integrator-zero lasts IZ_CYC system ticks. The capture strobe is high for exactly one clock, in the clock where the code turns to 01, and result, polarity and overrange take their new values in that same clock.
- R7: The data-valid output is low exactly while the phase code is 01.
- R8: A system tick that sees the enable high forces code 01 from any phase, restarts the auto-zero timer and captures nothing. After release, a full auto-zero period follows.
- R9: The system tick occurs every SYS_DIV clocks, and phase changes happen only on system ticks.
- R10: While the enable stays low, conversions repeat without a break.
- R11: In reset the code is 01, data-valid is low, and result, polarity, overrange and strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Converter zero-crossing comparator output |
| conv_en_n | input | 1 | Active-low conversion enable |
| load_val | input | LV_W (8) | Integrate/auto-zero duration in prescaler units, minus one |
| range_sel | input | 1 | 1 selects the full counter range, 0 selects half range |
| phase_o | output | 2 | Converter phase code |
| dv_n_o | output | 1 | Active-low data valid |
| result_o | output | CNT_W (16) | De-integrate count of the last conversion |
| pol_o | output | 1 | Input polarity of the last conversion (1 = positive) |
| ovr_o | output | 1 | Overrange flag of the last conversion |
| cap_stb_o | output | 1 | One-clock capture strobe for the result register |

## Verification
The bench sweeps small load values and de-integrate lengths and measures each phase's duration in clocks. An off-by-one in the prescaled timer or the tick divider would show up as a wrong duration. It places the comparator fall on the very first de-integrate tick and also on the saturating tick. A design that compared against the limit before checking the edge would flag overrange on a valid full-scale reading. With range select 0 and 1, the bench confirms that a missing fall stops at the matching limit. It also forces auto-zero in the middle of de-integrate. A design that captured on abort, or that failed to restart the auto-zero timer, would show a stray strobe, a changed result or a short auto-zero.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_IZ  = 2'b00,
    PH_AZ  = 2'b01,
    PH_INT = 2'b10,
    PH_DEI = 2'b11
  } phase_e;
endpackage

// File: rtl/dsq_tick_gen.sv
// System tick: one clock-enable pulse every DIV clocks (DIV >= 2).
module dsq_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == DW'(DIV-1)) ? '0 : cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == DW'(DIV-1));
endmodule

// File: rtl/dsq_timebase.sv
// Prescaled phase timer: low PS_W bits are the prescaler, upper bits the unit count.
module dsq_timebase #(
  parameter int LV_W   = 8,
  parameter int PS_W   = 8,
  parameter int IZ_CYC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clr,
  input  logic            sel_iz,
  input  logic [LV_W-1:0] lv,
  output logic            done
);
  localparam int TW = LV_W + PS_W + 1;

  logic [TW-1:0] tmr_q, tmr_d, lim;

  always_comb begin
    lim   = sel_iz ? TW'(IZ_CYC-1) : (((TW'(lv) + TW'(1)) << PS_W) - TW'(1));
    tmr_d = tmr_q;
    if (tick) tmr_d = clr ? '0 : tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign done = tick && (tmr_q == lim);
endmodule

// File: rtl/dsq_deint_cnt.sv
// De-integrate counter with comparator falling-edge detect and full-scale compare.
module dsq_deint_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp_i,
  input  logic             active,
  input  logic             range_full,
  output logic             fall,
  output logic             sat,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             cmp_q, cmp_d;

  always_comb begin
    lim   = range_full ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
    cnt_d = cnt_q;
    cmp_d = cmp_q;
    if (tick) begin
      cnt_d = active ? cnt_q + CNT_W'(1) : '0;
      cmp_d = cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign fall = tick && active && cmp_q && !cmp_i;
  assign sat  = tick && active && (cnt_q == lim);
  assign cnt  = cnt_q;
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
  import dsq_pkg::*;
#(
  parameter int SYS_DIV = 4,
  parameter int PRE_DIV = 256,
  parameter int CNT_W   = 16,
  parameter int LV_W    = 8,
  parameter int IZ_CYC  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic             conv_en_n,
  input  logic [LV_W-1:0]  load_val,
  input  logic             range_sel,
  output logic [1:0]       phase_o,
  output logic             dv_n_o,
  output logic [CNT_W-1:0] result_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             cap_stb_o
);
  localparam int PS_W = $clog2(PRE_DIV);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic             sys_tick, tb_done, dc_fall, dc_sat, clr;
  logic [CNT_W-1:0] dc_cnt;
  phase_e           ph_q, ph_d;
  logic             init_q, init_d;
  logic [LV_W-1:0]  lv_q;
  logic             lv_ld, cap, dv_d, dv_q, stb_q;
  logic [CNT_W-1:0] res_hd, res_hd_d, res_q;
  logic             pol_hd, pol_hd_d, pol_q;
  logic             ovr_hd, ovr_hd_d, ovr_q;

  dsq_tick_gen #(.DIV(SYS_DIV)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(sys_tick)
  );

  dsq_timebase #(.LV_W(LV_W), .PS_W(PS_W), .IZ_CYC(IZ_CYC)) u_tb (
    .clk(clk), .rst_n(rst_s_n), .tick(sys_tick), .clr(clr),
    .sel_iz(ph_q == PH_IZ), .lv(lv_q), .done(tb_done)
  );

  dsq_deint_cnt #(.CNT_W(CNT_W)) u_dc (
    .clk(clk), .rst_n(rst_s_n), .tick(sys_tick), .cmp_i(cmp_i),
    .active(ph_q == PH_DEI), .range_full(range_sel),
    .fall(dc_fall), .sat(dc_sat), .cnt(dc_cnt)
  );

  // next-state logic
  always_comb begin
    ph_d     = ph_q;
    init_d   = init_q;
    clr      = 1'b0;
    cap      = 1'b0;
    res_hd_d = res_hd;
    pol_hd_d = pol_hd;
    ovr_hd_d = ovr_hd;
    if (sys_tick) begin
      if (conv_en_n || init_q) begin
        ph_d   = PH_AZ;
        clr    = 1'b1;
        init_d = 1'b0;
      end else begin
        case (ph_q)
          PH_AZ: if (tb_done) begin
            ph_d = PH_INT;
            clr  = 1'b1;
          end
          PH_INT: if (tb_done) begin
            ph_d     = PH_DEI;
            clr      = 1'b1;
            pol_hd_d = cmp_i;
          end
          PH_DEI: if (dc_fall || dc_sat) begin
            ph_d     = PH_IZ;
            clr      = 1'b1;
            res_hd_d = dc_cnt;
            ovr_hd_d = !dc_fall;
          end
          PH_IZ: if (tb_done) begin
            ph_d = PH_AZ;
            clr  = 1'b1;
            cap  = 1'b1;
          end
          default: ;
        endcase
      end
    end
    lv_ld = sys_tick && clr && (ph_d == PH_AZ);
    dv_d  = (ph_d != PH_AZ);
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q   <= PH_AZ;
      init_q <= 1'b1;
      lv_q   <= '0;
      res_hd <= '0;
      pol_hd <= 1'b0;
      ovr_hd <= 1'b0;
      res_q  <= '0;
      pol_q  <= 1'b0;
      ovr_q  <= 1'b0;
      stb_q  <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      init_q <= init_d;
      if (lv_ld) lv_q <= load_val;
      res_hd <= res_hd_d;
      pol_hd <= pol_hd_d;
      ovr_hd <= ovr_hd_d;
      if (cap) begin
        res_q <= res_hd;
        pol_q <= pol_hd;
        ovr_q <= ovr_hd;
      end
      stb_q <= cap;
      dv_q  <= dv_d;
    end
  end

  assign phase_o   = ph_q;
  assign dv_n_o    = dv_q;
  assign result_o  = res_q;
  assign pol_o     = pol_q;
  assign ovr_o     = ovr_q;
  assign cap_stb_o = stb_q;
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             conv_en_n,
  input logic [1:0]       phase,
  input logic             dv_n,
  input logic             stb,
  input logic             ovr,
  input logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF = {1'b0, {(CNT_W-1){1'b1}}};

  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |->
      (phase == 2'b01) ||
      ($past(phase) == 2'b01 && phase == 2'b10) ||
      ($past(phase) == 2'b10 && phase == 2'b11) ||
      ($past(phase) == 2'b11 && phase == 2'b00));

  a_r9_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> $past(tick));

  a_r7_dv_tracks_az: assert property (@(posedge clk) disable iff (!rst_n)
    dv_n == (phase != 2'b01));

  a_r6_strobe_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (phase == 2'b01 && $past(phase) == 2'b00));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  a_r8_forced_az: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(conv_en_n)) |-> (phase == 2'b01));

  a_r4_ovr_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (result == FULL || result == HALF));
endmodule

bind dslope_sequencer dsq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(sys_tick), .conv_en_n(conv_en_n),
  .phase(phase_o), .dv_n(dv_n_o), .stb(cap_stb_o), .ovr(ovr_o), .result(result_o)
);

// File: tb/dslope_sequencer_tb.sv
module dslope_sequencer_tb;
  localparam int D   = 2;
  localparam int PD  = 4;
  localparam int CW  = 8;
  localparam int IZC = 3;

  logic          clk = 1'b0;
  logic          rst_n, cmp, en_n, rng;
  logic [7:0]    lv;
  logic [1:0]    phase;
  logic          dv_n, pol, ovr, stb;
  logic [CW-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dslope_sequencer #(.SYS_DIV(D), .PRE_DIV(PD), .CNT_W(CW), .LV_W(8), .IZ_CYC(IZC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .conv_en_n(en_n), .load_val(lv),
    .range_sel(rng), .phase_o(phase), .dv_n_o(dv_n), .result_o(result),
    .pol_o(pol), .ovr_o(ovr), .cap_stb_o(stb)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts at the negedge where auto-zero has just begun; returns at the next one.
  task automatic run_conv(input int cur_lv, input int n, input bit pos,
                          input bit ovr_case, input int next_lv);
    int c;
    int lim;
    int exp_len;
    lim = rng ? 255 : 127;
    cmp = pos;
    c = 0;
    while (phase == 2'b01) begin
      if (c == 1) chk_eq("R6 strobe lasts one clock", int'(stb), 0);
      c++;
      @(negedge clk);
    end
    chk_eq("R2 R9 auto-zero length", c, (cur_lv + 1) * PD * D);
    chk_eq("R1 code after auto-zero", int'(phase), 2);
    chk_eq("R7 dv high outside auto-zero", int'(dv_n), 1);
    c = 0;
    while (phase == 2'b10) begin c++; @(negedge clk); end
    chk_eq("R2 integrate length", c, (cur_lv + 1) * PD * D);
    chk_eq("R1 code after integrate", int'(phase), 3);
    c = 0;
    while (phase == 2'b11) begin
      if (!ovr_case && c == n * D) cmp = 1'b0;
      else if (c == 0) cmp = 1'b1;
      c++;
      @(negedge clk);
    end
    exp_len = ovr_case ? (lim + 1) * D : (n + 1) * D;
    chk_eq("R3 R4 de-integrate length", c, exp_len);
    chk_eq("R1 code after de-integrate", int'(phase), 0);
    lv = 8'(next_lv);
    c = 0;
    while (phase == 2'b00) begin c++; @(negedge clk); end
    chk_eq("R6 integrator-zero length", c, IZC * D);
    chk_eq("R1 code back to auto-zero", int'(phase), 1);
    chk_eq("R6 strobe at auto-zero entry", int'(stb), 1);
    chk_eq("R7 dv low in auto-zero", int'(dv_n), 0);
    chk_eq("R3 R4 result", int'(result), ovr_case ? lim : n);
    chk_eq("R4 overrange flag", int'(ovr), int'(ovr_case));
    chk_eq("R5 polarity", int'(pol), int'(pos));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    int seen;
    rst_n = 1'b0; cmp = 1'b1; en_n = 1'b0; rng = 1'b1; lv = 8'd1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk_eq("R11 reset code", int'(phase), 1);
    chk_eq("R11 reset dv", int'(dv_n), 0);
    chk_eq("R11 reset result", int'(result), 0);
    chk_eq("R11 reset strobe", int'(stb), 0);
    chk_eq("R11 reset overrange", int'(ovr), 0);
    chk_eq("R11 reset polarity", int'(pol), 0);
    rst_n = 1'b1;
    // warm-up conversion
    while (phase != 2'b11) @(negedge clk);
    cmp = 1'b0;
    while (phase != 2'b01) @(negedge clk);

    // R10: back-to-back conversions under a low enable
    run_conv(1, 0, 1'b1, 1'b0, 0);
    run_conv(0, 5, 1'b1, 1'b0, 2);
    run_conv(2, 3, 1'b0, 1'b0, 3);
    run_conv(3, 37, 1'b0, 1'b0, 1);
    for (int n = 1; n <= 8; n++) run_conv(1, n, n[0], 1'b0, 1);

    // R4 half range: near limit, fall on the saturating tick, then no fall
    rng = 1'b0;
    run_conv(1, 126, 1'b1, 1'b0, 1);
    run_conv(1, 127, 1'b1, 1'b0, 1);
    run_conv(1, 0, 1'b1, 1'b1, 1);
    // R4 full range
    rng = 1'b1;
    run_conv(1, 200, 1'b0, 1'b0, 1);
    run_conv(1, 0, 1'b1, 1'b1, 1);

    // R8 forced auto-zero in the middle of de-integrate
    r0 = int'(result);
    cmp = 1'b1;
    while (phase != 2'b11) @(negedge clk);
    en_n = 1'b1;
    seen = 0;
    while (phase == 2'b11) begin seen++; @(negedge clk); end
    chk_eq("R8 forced within one tick", seen, D);
    chk_eq("R8 forced code", int'(phase), 1);
    chk_eq("R8 dv low while forced", int'(dv_n), 0);
    seen = 0;
    repeat (5 * D) begin
      if (stb || phase != 2'b01) seen++;
      @(negedge clk);
    end
    chk_eq("R8 held in auto-zero without strobe", seen, 0);
    chk_eq("R8 result kept after abort", int'(result), r0);
    en_n = 1'b0;
    run_conv(1, 4, 1'b1, 1'b0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule